// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Flags

This block is the arithmetic and logic core of an accumulator machine. It takes an operation code, the current accumulator value, a second operand and the carry flag left by the previous instruction. In the same cycle it returns the new result, a write strobe for the accumulator and six status flags. It holds no state. The surrounding datapath registers the result and the flags, and decides where the second operand comes from.

Eight operations share one adder/subtractor and one bitwise unit: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Compare runs the subtract path only to produce flags. Its strobe stays low, so the accumulator keeps its value. One flag bit has two meanings: arithmetic operations put signed overflow in it, and bitwise operations put even parity of the result in it.

Top module: `alu8_acc`

## Requirements
- R1: `op_i` selects the operation with this encoding: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare.
- R2: For codes 0 and 1, `res_o` is `acc_i + opnd_i + cin` modulo 256, where cin is `cy_i` for code 1 and 0 for code 0. `carry_o` is the carry out of bit 7.
- R3: For codes 2, 3 and 7, `res_o` is `acc_i - opnd_i - bin` modulo 256, where bin is `cy_i` for code 3 and 0 otherwise. `carry_o` is 1 when the subtraction borrows out of bit 7.
- R4: For arithmetic codes, `half_o` is the carry (add) or the borrow (subtract) out of bit 3.
- R5: For codes 0, 1, 2, 3 and 7, `pv_o` is 1 exactly when the two's-complement result overflows the signed 8-bit range.
- R6: For codes 4, 5 and 6, `res_o` is the bitwise result and `pv_o` is 1 when it has an even number of ones. `carry_o` and `sub_o` are 0. `half_o` is 1 for AND and 0 for XOR and OR.
- R7: `sub_o` is 1 for codes 2, 3 and 7, and 0 for codes 0 and 1.
- R8: `sign_o` equals bit 7 of `res_o`, and `zero_o` is 1 exactly when all bits of `res_o` are 0.
- R9: `acc_we_o` is 0 for compare (code 7) and 1 for every other code. For compare, `res_o` still shows the difference.
- R10: `cy_i` has no effect on any output for codes 0, 2, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Operation result (the difference for compare) |
| acc_we_o | output | 1 | Accumulator write strobe |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| half_o | output | 1 | Half-carry flag |
| pv_o | output | 1 | Parity or overflow flag |
| sub_o | output | 1 | Subtract flag |
| carry_o | output | 1 | Carry or borrow flag |

## Verification
The arithmetic operations are tried with operand pairs chosen to hit boundaries:
- 0x7F plus 1 separates signed overflow from unsigned carry.
- 0xFF plus 1 produces carry and zero together.
- 0x0F plus 1 produces a half-carry alone.
- 0x80 minus 1 and 0 minus 1 separate a signed overflow from a borrow.

Bitwise operations use operands whose results have odd and even numbers of ones, which tells parity apart from overflow in the shared bit. Compare is tried with equal, smaller and larger operands. The carry-in is toggled on the operations that must ignore it. A strided sweep over all eight codes compares every output against an integer model of the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_XOR = 3'd5,
      OP_OR  = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic half;
      logic pv;
      logic sub;
      logic carry;
   } alu_flags_t;

   // Operations routed through the adder/subtractor
   function automatic logic op_is_arith(alu_op_e op);
      return (op == OP_CMP) || !op[2];
   endfunction

   // Operations that invert the second operand
   function automatic logic op_is_sub(alu_op_e op);
      return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
   endfunction

   // Operations that consume the incoming carry
   function automatic logic op_uses_cin(alu_op_e op);
      return (op == OP_ADC) || (op == OP_SBC);
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W   = 8,
   parameter int HALF_BIT = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              half_o,
   output logic              ovf_o
);
   localparam int MID_W = DATA_W - 1 - HALF_BIT;

   logic [DATA_W-1:0] b_eff;
   logic              c_in0;
   logic [HALF_BIT:0] lo_sum;
   logic [MID_W:0]    mid_sum;
   logic [1:0]        top_sum;

   // Subtraction is addition of the inverted operand with the borrow inverted.
   assign b_eff = sub_i ? ~b_i : b_i;
   assign c_in0 = sub_i ? ~cin_i : cin_i;

   // Low segment ends at the half-carry tap.
   assign lo_sum  = {1'b0, a_i[HALF_BIT-1:0]} + {1'b0, b_eff[HALF_BIT-1:0]}
                  + {{HALF_BIT{1'b0}}, c_in0};
   // Middle segment stops below the sign bit, exposing the carry into it.
   assign mid_sum = {1'b0, a_i[DATA_W-2:HALF_BIT]} + {1'b0, b_eff[DATA_W-2:HALF_BIT]}
                  + {{MID_W{1'b0}}, lo_sum[HALF_BIT]};
   // Sign bit on its own.
   assign top_sum = {1'b0, a_i[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                  + {1'b0, mid_sum[MID_W]};

   assign sum_o  = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[HALF_BIT-1:0]};
   assign cout_o = sub_i ^ top_sum[1];
   assign half_o = sub_i ^ lo_sum[HALF_BIT];
   assign ovf_o  = mid_sum[MID_W] ^ top_sum[1];

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              half_o
);
   always_comb begin
      res_o  = '0;
      half_o = 1'b0;
      unique case (op_i)
         OP_AND: begin
            res_o  = a_i & b_i;
            half_o = 1'b1;
         end
         OP_XOR: res_o = a_i ^ b_i;
         OP_OR:  res_o = a_i | b_i;
         default: begin
            res_o  = '0;
            half_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/alu8_parity.sv
module alu8_parity #(
   parameter int DATA_W    = 8,
   parameter bit RIPPLE    = 1'b0
) (
   input  logic [DATA_W-1:0] d_i,
   output logic              even_o
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = 1'b1;
         for (genvar i = 0; i < DATA_W; i++) begin : g_stage
            assign chain[i+1] = chain[i] ^ d_i[i];
         end
         assign even_o = chain[DATA_W];
      end else begin : g_reduce
         assign even_o = ~(^d_i);
      end
   endgenerate
endmodule

// File: rtl/alu8_acc.sv
module alu8_acc
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int HALF_BIT   = 4,
   parameter bit PAR_RIPPLE = 1'b0
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic              acc_we_o,
   output logic              sign_o,
   output logic              zero_o,
   output logic              half_o,
   output logic              pv_o,
   output logic              sub_o,
   output logic              carry_o
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("alu8_acc: DATA_W must be at least 4");
      end
      if (HALF_BIT < 1 || HALF_BIT > DATA_W - 2) begin : g_bad_half
         $error("alu8_acc: HALF_BIT must lie in 1..DATA_W-2");
      end
   endgenerate

   alu_op_e           op;
   logic              is_arith;
   logic              is_sub;
   logic              cin_sel;
   logic [DATA_W-1:0] as_sum;
   logic              as_cout;
   logic              as_half;
   logic              as_ovf;
   logic [DATA_W-1:0] bw_res;
   logic              bw_half;
   logic              bw_even;
   alu_flags_t        flags;

   assign op       = alu_op_e'(op_i);
   assign is_arith = op_is_arith(op);
   assign is_sub   = op_is_sub(op);
   assign cin_sel  = op_uses_cin(op) & cy_i;

   alu8_addsub #(.DATA_W(DATA_W), .HALF_BIT(HALF_BIT)) u_addsub (
      .a_i    (acc_i),
      .b_i    (opnd_i),
      .sub_i  (is_sub),
      .cin_i  (cin_sel),
      .sum_o  (as_sum),
      .cout_o (as_cout),
      .half_o (as_half),
      .ovf_o  (as_ovf)
   );

   alu8_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .op_i   (op),
      .a_i    (acc_i),
      .b_i    (opnd_i),
      .res_o  (bw_res),
      .half_o (bw_half)
   );

   alu8_parity #(.DATA_W(DATA_W), .RIPPLE(PAR_RIPPLE)) u_parity (
      .d_i    (bw_res),
      .even_o (bw_even)
   );

   always_comb begin
      if (is_arith) begin
         res_o       = as_sum;
         flags.half  = as_half;
         flags.pv    = as_ovf;
         flags.sub   = is_sub;
         flags.carry = as_cout;
      end else begin
         res_o       = bw_res;
         flags.half  = bw_half;
         flags.pv    = bw_even;
         flags.sub   = 1'b0;
         flags.carry = 1'b0;
      end
      flags.sign = res_o[MSB];
      flags.zero = ~|res_o;
   end

   assign acc_we_o = (op != OP_CMP);
   assign sign_o   = flags.sign;
   assign zero_o   = flags.zero;
   assign half_o   = flags.half;
   assign pv_o     = flags.pv;
   assign sub_o    = flags.sub;
   assign carry_o  = flags.carry;

endmodule

// File: rtl/alu8_acc_chk.sv
module alu8_acc_chk #(
   parameter int DATA_W = 8
) (
   input logic [2:0]        op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic              cy_i,
   input logic [DATA_W-1:0] res_o,
   input logic              acc_we_o,
   input logic              sign_o,
   input logic              zero_o,
   input logic              half_o,
   input logic              pv_o,
   input logic              sub_o,
   input logic              carry_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] add_ref;
   logic [DATA_W:0] sub_need;
   logic [DATA_W-1:0] sub_ref;
   logic            cin_add;
   logic            bin_sub;
   logic            known;

   always_comb begin
      known    = !$isunknown({op_i, acc_i, opnd_i, cy_i});
      cin_add  = (op_i == 3'd1) ? cy_i : 1'b0;
      bin_sub  = (op_i == 3'd3) ? cy_i : 1'b0;
      add_ref  = {1'b0, acc_i} + {1'b0, opnd_i} + {{DATA_W{1'b0}}, cin_add};
      sub_need = {1'b0, opnd_i} + {{DATA_W{1'b0}}, bin_sub};
      sub_ref  = acc_i - opnd_i - {{(DATA_W-1){1'b0}}, bin_sub};

      if (known) begin
         if (op_i == 3'd0 || op_i == 3'd1) begin
            p_add_sum_r2: assert ({carry_o, res_o} == add_ref)
               else $error("R2 add result/carry mismatch");
            p_add_ovf_r5: assert (pv_o == ((acc_i[MSB] == opnd_i[MSB]) && (res_o[MSB] != acc_i[MSB])))
               else $error("R5 add overflow mismatch");
         end
         if (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7) begin
            p_sub_diff_r3: assert (res_o == sub_ref && carry_o == ({1'b0, acc_i} < sub_need))
               else $error("R3 subtract result/borrow mismatch");
            p_sub_ovf_r5: assert (pv_o == ((acc_i[MSB] != opnd_i[MSB]) && (res_o[MSB] != acc_i[MSB])))
               else $error("R5 subtract overflow mismatch");
         end
         if (op_i[2] && op_i != 3'd7) begin
            p_logic_clear_r6: assert (!carry_o && !sub_o)
               else $error("R6 bitwise op left carry or subtract set");
         end
         if (op_i[2] == 1'b0 || op_i == 3'd7) begin
            p_sub_flag_r7: assert (sub_o == (op_i[1] || op_i[2]))
               else $error("R7 subtract flag mismatch");
         end
         p_cmp_hold_r9: assert (acc_we_o == (op_i != 3'd7))
            else $error("R9 write strobe mismatch");
         p_sign_r8: assert (sign_o == res_o[MSB] && zero_o == (res_o == '0))
            else $error("R8 sign/zero mismatch");
      end
   end
endmodule

bind alu8_acc alu8_acc_chk #(.DATA_W(DATA_W)) u_chk (
   .op_i     (op_i),
   .acc_i    (acc_i),
   .opnd_i   (opnd_i),
   .cy_i     (cy_i),
   .res_o    (res_o),
   .acc_we_o (acc_we_o),
   .sign_o   (sign_o),
   .zero_o   (zero_o),
   .half_o   (half_o),
   .pv_o     (pv_o),
   .sub_o    (sub_o),
   .carry_o  (carry_o)
);

// File: tb/tb_alu8_acc.sv
module tb_alu8_acc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_i = 3'd0;
   logic [7:0] acc_i = 8'h00;
   logic [7:0] opnd_i = 8'h00;
   logic       cy_i = 1'b0;
   logic [7:0] res_o;
   logic       acc_we_o, sign_o, zero_o, half_o, pv_o, sub_o, carry_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   alu8_acc dut (
      .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i),
      .res_o(res_o), .acc_we_o(acc_we_o), .sign_o(sign_o), .zero_o(zero_o),
      .half_o(half_o), .pv_o(pv_o), .sub_o(sub_o), .carry_o(carry_o)
   );

   // Expected {we, S, Z, H, PV, N, C, result} from integer arithmetic
   function automatic logic [14:0] model(input logic [2:0] op, input logic [7:0] a,
                                         input logic [7:0] s, input logic c);
      int ua = a, us = s, sa = $signed(a), ss = $signed(s), cc, t, sv, hn, ones;
      logic [7:0] r;
      logic h, pv, n, cy, we;
      we = (op != 3'd7);
      cc = (op == 3'd1 || op == 3'd3) ? int'(c) : 0;
      if (op == 3'd0 || op == 3'd1) begin
         t = ua + us + cc; sv = sa + ss + cc; hn = (ua % 16) + (us % 16) + cc;
         r = t[7:0]; cy = (t > 255); h = (hn > 15); pv = (sv > 127 || sv < -128); n = 1'b0;
      end else if (op == 3'd2 || op == 3'd3 || op == 3'd7) begin
         t = ua - us - cc; sv = sa - ss - cc; hn = (ua % 16) - (us % 16) - cc;
         r = t[7:0]; cy = (t < 0); h = (hn < 0); pv = (sv > 127 || sv < -128); n = 1'b1;
      end else begin
         r = (op == 3'd4) ? (a & s) : (op == 3'd5) ? (a ^ s) : (a | s);
         ones = 0;
         for (int i = 0; i < 8; i++) ones += int'(r[i]);
         pv = (ones % 2 == 0); cy = 1'b0; n = 1'b0; h = (op == 3'd4);
      end
      return {we, r[7], (r == 8'h00), h, pv, n, cy, r};
   endfunction

   task automatic check_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] s,
                           input logic c, input string tag);
      logic [14:0] exp, act;
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = s; cy_i = c;
      #1;
      exp = model(op, a, s, c);
      act = {acc_we_o, sign_o, zero_o, half_o, pv_o, sub_o, carry_o, res_o};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s op=%0d a=%h s=%h c=%0b actual=%h expected=%h",
                  tag, op, a, s, c, act, exp);
      end
   endtask

   // Reset state: all-zero inputs give add of zeros
   task automatic t_reset;
      check_op(3'd0, 8'h00, 8'h00, 1'b0, "R8 zero result after reset");
   endtask

   task automatic t_add;
      check_op(3'd0, 8'h12, 8'h34, 1'b0, "R2 plain add");
      check_op(3'd0, 8'h7F, 8'h01, 1'b0, "R5 add signed overflow");
      check_op(3'd0, 8'hFF, 8'h01, 1'b0, "R2 add carry with zero R8");
      check_op(3'd0, 8'h0F, 8'h01, 1'b0, "R4 add half carry");
      check_op(3'd1, 8'h0F, 8'h00, 1'b1, "R2 add with carry-in set R4");
      check_op(3'd1, 8'h7F, 8'h00, 1'b1, "R5 adc overflow via carry-in");
      check_op(3'd1, 8'hFF, 8'hFF, 1'b1, "R2 adc full carry");
   endtask

   task automatic t_sub;
      check_op(3'd2, 8'h80, 8'h01, 1'b0, "R5 subtract signed overflow");
      check_op(3'd2, 8'h00, 8'h01, 1'b0, "R3 subtract borrow");
      check_op(3'd2, 8'h10, 8'h01, 1'b0, "R4 subtract half borrow");
      check_op(3'd3, 8'h05, 8'h05, 1'b1, "R3 sbc borrow-in");
      check_op(3'd3, 8'h05, 8'h04, 1'b1, "R7 sbc to zero");
   endtask

   task automatic t_logic;
      check_op(3'd4, 8'hF0, 8'h3C, 1'b0, "R6 AND even parity");
      check_op(3'd4, 8'h07, 8'h01, 1'b0, "R6 AND odd parity");
      check_op(3'd5, 8'hAA, 8'hAB, 1'b0, "R6 XOR odd parity");
      check_op(3'd5, 8'h55, 8'h55, 1'b0, "R6 XOR zero result");
      check_op(3'd6, 8'h80, 8'h01, 1'b0, "R6 OR sign set");
   endtask

   task automatic t_compare;
      check_op(3'd7, 8'h42, 8'h42, 1'b0, "R9 compare equal");
      check_op(3'd7, 8'h10, 8'h20, 1'b0, "R9 compare smaller");
      check_op(3'd7, 8'h80, 8'h7F, 1'b0, "R9 compare larger with overflow");
   endtask

   task automatic t_cin_ignored;
      check_op(3'd0, 8'h3F, 8'h40, 1'b1, "R10 add ignores carry-in");
      check_op(3'd2, 8'h30, 8'h10, 1'b1, "R10 subtract ignores carry-in");
      check_op(3'd4, 8'hFF, 8'h0F, 1'b1, "R10 AND ignores carry-in");
      check_op(3'd5, 8'hFF, 8'h0F, 1'b1, "R10 XOR ignores carry-in");
      check_op(3'd6, 8'h00, 8'h00, 1'b1, "R10 OR ignores carry-in");
      check_op(3'd7, 8'h01, 8'h01, 1'b1, "R10 compare ignores carry-in");
   endtask

   task automatic t_sweep;
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 256; a += 23)
            for (int s = 0; s < 256; s += 29)
               for (int c = 0; c < 2; c++)
                  check_op(op[2:0], a[7:0], s[7:0], c[0], "R1 decode sweep");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_compare();
      t_cin_ignored();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule